// File: doc/BRIEF.md
# Two-Channel Serial PCM Frame Transmitter with Control Echo

This block puts a 28-slot, two-channel voice frame onto an open-drain serial line. A rising edge on the transmit frame-sync input starts a frame. At that moment the block captures each channel's 8-bit companded sample, its power state and its three latched control bits. It then sends one slot per bit-clock rising edge, most significant bit first. Each channel's field ends with an echo of its power state and its latched control bits, so the host on the other side of the highway can confirm what the codec has latched.

The block works in a single system clock domain. The bit clock reaches it as `bit_tick`, a one-cycle strobe that marks each rising edge of the bit clock. The line is modelled as a pull-down enable (`line_oe`) and the value the line resolves to (`line_d`). A 0 bit pulls the line low. A 1 bit, an empty slot, an idle slot or any slot during global power-down releases the line. A channel that is powered down sends the positive-zero code 8'hFF in its sample field. When the global power-down input is low, the line is released and any frame in progress is abandoned.

Top module: `pcm_echo_tx`

## Requirements
- R1: While `rst` is high, and after it until the first frame starts, the line is released (`line_oe`=0, `line_d`=1).
- R2: A frame starts on the first cycle in which `fsync` is high after being low, provided `glob_pdn`=1. Slot 1 is presented in the following cycle without waiting for `bit_tick`. A `fsync` held high does not start the frame again.
- R3: Each `bit_tick` inside a frame advances one slot. Slot layout, with the MSB first in each sample: slots 1-8 carry the channel-1 sample; slot 9 the channel-1 power bit; slots 10, 11 and 12 carry `ch1_latch` bits 2, 1 and 0; slots 13-16 are empty (released); slots 17-24 carry the channel-2 sample; slot 25 the channel-2 power bit; slots 26, 27 and 28 carry `ch2_latch` bits 2, 1 and 0.
- R4: When a channel's power input (`chN_pwr`) is 0 at frame start, its sample field is sent as 8'hFF and its power echo slot carries 0. Its latch echo still carries the latched bits.
- R5: While `glob_pdn`=0 the line is released. A frame in progress is aborted and stays released for the rest of its slots. A `fsync` rise seen while `glob_pdn`=0 starts no frame.
- R6: After slot 28, the line stays released, whatever `bit_tick` does, until the next frame start.
- R7: Samples, power bits and latch bits are captured at frame start. Changes to those inputs during a frame do not alter the bits sent.
- R8: The output is open-drain. A 0 bit gives `line_oe`=1 and `line_d`=0, and a 1 bit gives `line_oe`=0 and `line_d`=1. `line_d` is never 1 while `line_oe` is 1.
- R9: A `fsync` rise in the middle of a frame restarts at slot 1 with freshly captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe marking a bit-clock rising edge |
| fsync | input | 1 | Transmit frame sync; its rising edge starts a frame |
| glob_pdn | input | 1 | Global power control; 0 releases the line and aborts the frame |
| ch1_code | input | 8 | Channel-1 companded sample |
| ch1_pwr | input | 1 | Channel-1 power state (1 = operating) |
| ch1_latch | input | 3 | Channel-1 latched control bits |
| ch2_code | input | 8 | Channel-2 companded sample |
| ch2_pwr | input | 1 | Channel-2 power state (1 = operating) |
| ch2_latch | input | 3 | Channel-2 latched control bits |
| line_d | output | 1 | Resolved line value (1 when released) |
| line_oe | output | 1 | Pull-down enable of the open-drain line |

## Verification
The hardest situation to reach from the ports is a frame that is abandoned part-way through by global power-down, combined with a sync rise that arrives while power is still down. The stimulus starts a frame whose first sample bits are zeros, so the line is visibly pulled low. It then drops `glob_pdn` mid-field and raises `fsync` during the power-down. After power returns, it keeps ticking and confirms that the line stays released with no new frame. Capture-at-start is exercised by inverting every channel input right after slot 3, and restart by raising sync at slot 10 of a running frame.

// File: rtl/pcm_tx_pkg.sv
`timescale 1ns/1ps
package pcm_tx_pkg;

    localparam int PCM_W       = 8;
    localparam int LATCH_W     = 3;
    localparam int NCH         = 2;
    localparam int HALF_SLOTS  = 16;
    localparam int FIELD_W     = PCM_W + 1 + LATCH_W;
    localparam int GAP_W       = HALF_SLOTS - FIELD_W;
    localparam int FRAME_SLOTS = HALF_SLOTS + FIELD_W;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS + 1);
    localparam int IDX_W       = $clog2(FRAME_SLOTS);

    localparam logic [PCM_W-1:0] IDLE_CODE = '1;

    typedef struct packed {
        logic [PCM_W-1:0]   code;
        logic               pwr;
        logic [LATCH_W-1:0] ltch;
    } chan_field_t;

    typedef logic [FRAME_SLOTS-1:0] frame_word_t;

    typedef enum logic [1:0] {
        SEG_IDLE,
        SEG_CH1,
        SEG_GAP,
        SEG_CH2
    } seg_e;

    function automatic frame_word_t assemble(chan_field_t f1, chan_field_t f2);
        return {f1, {GAP_W{1'b1}}, f2};
    endfunction

    function automatic seg_e slot_segment(logic [SLOT_W-1:0] s);
        int si;
        si = int'(s);
        if (si == 0 || si > FRAME_SLOTS) return SEG_IDLE;
        else if (si <= FIELD_W)           return SEG_CH1;
        else if (si <= HALF_SLOTS)        return SEG_GAP;
        else                              return SEG_CH2;
    endfunction

endpackage

// File: rtl/pcm_tx_slot_ctr.sv
`timescale 1ns/1ps
module pcm_tx_slot_ctr
    import pcm_tx_pkg::*;
#(
    parameter int SLOTS = FRAME_SLOTS,
    localparam int W    = $clog2(SLOTS + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic         advance,
    output logic [W-1:0] slot_o
);

    logic [W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            slot_q <= '0;
        end else if (start) begin
            slot_q <= W'(1);
        end else if (advance && slot_q != '0) begin
            if (slot_q == W'(SLOTS)) slot_q <= '0;
            else                     slot_q <= slot_q + W'(1);
        end
    end

    assign slot_o = slot_q;

    assert_slot_range_R3: assert property (@(posedge clk) disable iff (rst)
        slot_q <= W'(SLOTS));

    assert_slot_step_R3: assert property (@(posedge clk) disable iff (rst)
        (advance && !start && !abort && slot_q != '0 && slot_q != W'(SLOTS))
        |=> slot_q == $past(slot_q) + W'(1));

    assert_frame_end_R6: assert property (@(posedge clk) disable iff (rst)
        (advance && !start && !abort && slot_q == W'(SLOTS)) |=> slot_q == '0);

    assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
        abort |=> slot_q == '0);

endmodule

// File: rtl/pcm_tx_frame_reg.sv
`timescale 1ns/1ps
module pcm_tx_frame_reg
    import pcm_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  chan_field_t raw_i [NCH],
    output frame_word_t word_o
);

    chan_field_t field_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                field_q[g] <= '1;
            end else if (start) begin
                field_q[g].code <= raw_i[g].pwr ? raw_i[g].code : IDLE_CODE;
                field_q[g].pwr  <= raw_i[g].pwr;
                field_q[g].ltch <= raw_i[g].ltch;
            end
        end

        assert_idle_fill_R4: assert property (@(posedge clk) disable iff (rst)
            !field_q[g].pwr |-> field_q[g].code == IDLE_CODE);
    end

    assign word_o = assemble(field_q[0], field_q[1]);

    assert_hold_frame_R7: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(word_o));

endmodule

// File: rtl/pcm_tx_line_drv.sv
`timescale 1ns/1ps
module pcm_tx_line_drv
    import pcm_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              glob_pdn,
    input  logic [SLOT_W-1:0] slot_i,
    input  frame_word_t       word_i,
    output logic              line_d,
    output logic              line_oe
);

    logic             bit_v;
    logic [IDX_W-1:0] idx;

    always_comb begin
        bit_v = 1'b1;
        idx   = '0;
        if (slot_i != '0) begin
            idx   = IDX_W'(FRAME_SLOTS - int'(slot_i));
            bit_v = word_i[idx];
        end
    end

    assign line_oe = glob_pdn && (slot_i != '0) && !bit_v;
    assign line_d  = !line_oe;

    assert_open_drain_R8: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> !line_d);

    assert_global_pd_R5: assert property (@(posedge clk) disable iff (rst)
        !glob_pdn |-> !line_oe);

    assert_idle_release_R6: assert property (@(posedge clk) disable iff (rst)
        slot_i == '0 |-> (!line_oe && line_d));

endmodule

// File: rtl/pcm_echo_tx.sv
`timescale 1ns/1ps
module pcm_echo_tx
    import pcm_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_tick,
    input  logic               fsync,
    input  logic               glob_pdn,
    input  logic [PCM_W-1:0]   ch1_code,
    input  logic               ch1_pwr,
    input  logic [LATCH_W-1:0] ch1_latch,
    input  logic [PCM_W-1:0]   ch2_code,
    input  logic               ch2_pwr,
    input  logic [LATCH_W-1:0] ch2_latch,
    output logic               line_d,
    output logic               line_oe
);

    logic              fsync_q;
    logic              start;
    logic              abort;
    logic [SLOT_W-1:0] slot;
    chan_field_t       raw [NCH];
    frame_word_t       word;

    always_ff @(posedge clk) begin
        if (rst) fsync_q <= 1'b0;
        else     fsync_q <= fsync;
    end

    assign start  = fsync && !fsync_q && glob_pdn;
    assign abort  = !glob_pdn;
    assign raw[0] = {ch1_code, ch1_pwr, ch1_latch};
    assign raw[1] = {ch2_code, ch2_pwr, ch2_latch};

    pcm_tx_slot_ctr #(.SLOTS(FRAME_SLOTS)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .abort   (abort),
        .advance (bit_tick),
        .slot_o  (slot)
    );

    pcm_tx_frame_reg u_frame (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .raw_i  (raw),
        .word_o (word)
    );

    pcm_tx_line_drv u_line (
        .clk      (clk),
        .rst      (rst),
        .glob_pdn (glob_pdn),
        .slot_i   (slot),
        .word_i   (word),
        .line_d   (line_d),
        .line_oe  (line_oe)
    );

    assert_start_slot1_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> slot == SLOT_W'(1));

    assert_gap_release_R3: assert property (@(posedge clk) disable iff (rst)
        slot_segment(slot) == SEG_GAP |-> !line_oe);

    assert_reset_release_R1: assert property (@(posedge clk)
        rst |=> (!line_oe && line_d));

endmodule

// File: tb/pcm_echo_tx_test.sv
`timescale 1ns/1ps
module pcm_echo_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       fsync = 1'b0;
    logic       glob_pdn = 1'b1;
    logic [7:0] ch1_code = 8'h00;
    logic       ch1_pwr = 1'b1;
    logic [2:0] ch1_latch = 3'b000;
    logic [7:0] ch2_code = 8'h00;
    logic       ch2_pwr = 1'b1;
    logic [2:0] ch2_latch = 3'b000;
    logic       line_d;
    logic       line_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pcm_echo_tx uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .fsync(fsync),
        .glob_pdn(glob_pdn),
        .ch1_code(ch1_code), .ch1_pwr(ch1_pwr), .ch1_latch(ch1_latch),
        .ch2_code(ch2_code), .ch2_pwr(ch2_pwr), .ch2_latch(ch2_latch),
        .line_d(line_d), .line_oe(line_oe)
    );

    function automatic logic exp_slot(int s, logic [7:0] c1, logic p1, logic [2:0] l1,
                                      logic [7:0] c2, logic p2, logic [2:0] l2);
        if (s >= 1 && s <= 8)        return p1 ? c1[8 - s] : 1'b1;
        else if (s == 9)             return p1;
        else if (s >= 10 && s <= 12) return l1[12 - s];
        else if (s >= 17 && s <= 24) return p2 ? c2[24 - s] : 1'b1;
        else if (s == 25)            return p2;
        else if (s >= 26 && s <= 28) return l2[28 - s];
        else                         return 1'b1;
    endfunction

    task automatic chk(string tag, int slot, logic e);
        checks++;
        if (line_oe !== !e || line_d !== e) begin
            errors++;
            $display("FAIL %s slot %0d: oe=%b d=%b expected oe=%b d=%b",
                     tag, slot, line_oe, line_d, !e, e);
        end
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_frame(logic [7:0] c1, logic p1, logic [2:0] l1,
                               logic [7:0] c2, logic p2, logic [2:0] l2);
        ch1_code = c1; ch1_pwr = p1; ch1_latch = l1;
        ch2_code = c2; ch2_pwr = p2; ch2_latch = l2;
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
    endtask

    task automatic run_frame(string tag, logic [7:0] c1, logic p1, logic [2:0] l1,
                             logic [7:0] c2, logic p2, logic [2:0] l2, bit mutate);
        start_frame(c1, p1, l1, c2, p2, l2);
        for (int s = 1; s <= 28; s++) begin
            chk(tag, s, exp_slot(s, c1, p1, l1, c2, p2, l2));
            if (mutate && s == 3) begin
                ch1_code = ~c1; ch1_pwr = ~p1; ch1_latch = ~l1;
                ch2_code = ~c2; ch2_pwr = ~p2; ch2_latch = ~l2;
            end
            tick();
        end
        chk({tag, " R6 after slot 28"}, 0, 1'b1);
        tick();
        tick();
        chk({tag, " R6 ticks outside frame"}, 0, 1'b1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 during reset", 0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        tick();
        chk("R1 after reset, no frame", 0, 1'b1);
    endtask

    task automatic t_normal();
        run_frame("R3 R8 pattern A", 8'hA5, 1'b1, 3'b101, 8'h3C, 1'b1, 3'b010, 1'b0);
        run_frame("R3 R8 pattern B", 8'h00, 1'b1, 3'b000, 8'hFE, 1'b1, 3'b111, 1'b0);
        run_frame("R3 R2 pattern C", 8'h81, 1'b1, 3'b011, 8'h7F, 1'b1, 3'b100, 1'b0);
    endtask

    task automatic t_chan_down();
        run_frame("R4 ch1 down", 8'h12, 1'b0, 3'b110, 8'h34, 1'b1, 3'b001, 1'b0);
        run_frame("R4 ch2 down", 8'h56, 1'b1, 3'b001, 8'h00, 1'b0, 3'b101, 1'b0);
    endtask

    task automatic t_mutate();
        run_frame("R7 mid-frame input change", 8'h4B, 1'b1, 3'b010, 8'hC3, 1'b0, 3'b110, 1'b1);
    endtask

    task automatic t_global_pd();
        start_frame(8'h0F, 1'b1, 3'b000, 8'h00, 1'b1, 3'b000);
        for (int s = 1; s <= 4; s++) begin
            chk("R5 before power-down", s, 1'b0);
            tick();
        end
        glob_pdn = 1'b0;
        #1;
        chk("R5 released while pdn low", 5, 1'b1);
        @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        chk("R5 sync while pdn low", 0, 1'b1);
        fsync = 1'b0;
        glob_pdn = 1'b1;
        @(negedge clk);
        chk("R5 aborted after pdn high", 0, 1'b1);
        for (int k = 0; k < 6; k++) tick();
        chk("R5 frame stays aborted", 0, 1'b1);
    endtask

    task automatic t_restart();
        start_frame(8'hFF, 1'b1, 3'b111, 8'hFF, 1'b1, 3'b111);
        for (int s = 1; s < 10; s++) tick();
        chk("R9 old frame slot 10", 10, 1'b1);
        run_frame("R9 restarted frame", 8'h00, 1'b1, 3'b000, 8'h55, 1'b1, 3'b010, 1'b0);
    endtask

    task automatic t_held_sync();
        ch1_code = 8'hB2; ch1_pwr = 1'b1; ch1_latch = 3'b001;
        ch2_code = 8'h00; ch2_pwr = 1'b1; ch2_latch = 3'b000;
        fsync = 1'b1;
        @(negedge clk);
        chk("R2 slot 1 before any tick", 1, 1'b1);
        for (int s = 2; s <= 5; s++) begin
            tick();
            chk("R2 held sync does not restart", s,
                exp_slot(s, 8'hB2, 1'b1, 3'b001, 8'h00, 1'b1, 3'b000));
        end
        fsync = 1'b0;
        for (int s = 6; s <= 28; s++) tick();
        tick();
        chk("R6 after held-sync frame", 0, 1'b1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_chan_down();
        t_mutate();
        t_global_pd();
        t_restart();
        t_held_sync();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule